// File: doc/BRIEF.md
# Power-Management Capability Registers

This block holds the power-management register set of a PCI-style function. A small configuration port reads and writes it. The port has a word address, two byte enables and a one-cycle write strobe. Address 0 returns a fixed capabilities word. Address 1 is the 16-bit control/status word. Address 2 returns, in its low byte, the data value that the data-select field picks.

Software writes the control/status word to move the function between the D0..D3 states. Only states that a parameter mask marks as supported are accepted. Software also uses this word to enable PME generation and to choose a data value. A one-cycle wake input sets a sticky PME status bit whether or not PME is enabled. The registered PME request output is high while status and enable are both set. Writing one to the status bit clears it and drops the request.

The current power state is driven on its own output for the surrounding power logic.

Top module: `pm_csr_block`

## Requirements
- R1: After reset the power state is D0 (`pwr_state`=00) and `pme_req` is 0. The control/status word reads 0x2000, so status, enable and select are 0 and only the scale reads 01. `data_byte` shows table entry 0.
- R2: A write to address 1 with `cfg_be[0]`=1 and a supported state code in bits 1:0 sets `pwr_state` and the read-back field to that code after the write edge. The codes are 00=D0, 01=D1, 10=D2 and 11=D3.
- R3: D0 and D3 are always supported. D1 is supported only when `STATE_MASK[0]`=1, and D2 only when `STATE_MASK[1]`=1. A write that requests an unsupported state leaves the state unchanged.
- R4: A cycle with `wake_evt`=1 sets PME status (bit 15) at the next edge, whatever the value of PME enable.
- R5: Writing 1 to bit 15 with `cfg_be[1]`=1 clears PME status and drops `pme_req` at the same edge. Writing 0 to bit 15 leaves it unchanged.
- R6: `pme_req` is a flop equal to PME status AND PME enable (bit 8), both taken as they stand after the same edge.
- R7: When a wake event and a clearing write fall in the same cycle, PME status ends up set.
- R8: Data scale (bits 14:13) always reads 01. Reserved bits 7:2 always read 0. Writes to either field have no effect.
- R9: PME enable (bit 8) and data select (bits 12:9) are read/write through `cfg_be[1]`.
- R10: `data_byte` and the low byte at address 2 give byte *n* of `DATA_TABLE` (bits 8n+7:8n) for select codes 0..7, and 0 for codes 8..15.
- R11: Address 0 reads version 010 in bits 2:0, zero in bits 8:3, D1 support in bit 9, D2 support in bit 10, and `PME_STATES` in bits 15:11.
- R12: `cfg_be[0]` gates writes to bits 7:0 and `cfg_be[1]` gates writes to bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_addr | input | 2 | Word address: 0 capabilities, 1 control/status, 2 data byte |
| cfg_be | input | 2 | Byte enables for the write data |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data for `cfg_addr`, combinational from the registers |
| wake_evt | input | 1 | One-cycle wake event |
| pme_req | output | 1 | Registered PME request |
| pwr_state | output | 2 | Current power state |
| data_byte | output | 8 | Data value picked by data select |

## Verification
Every register result is due one edge after its stimulus. Writes and wake events are driven at the falling edge, the rising edge commits them, and the bench reads `cfg_rdata`, `pme_req` and `pwr_state` at the following falling edge. `pme_req` is computed from the next-state values, so it is due in the same cycle as the status bit it depends on, not one cycle later. `data_byte` and the address-2 read are combinational from the select register, so they are checked at the falling edge after the write that changes the select.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int CSR_W     = 16;
  localparam int SEL_W     = 4;
  localparam int PS_W      = 2;
  localparam int BIT_STAT  = 15;
  localparam int BIT_EN    = 8;
  localparam int SEL_LO    = 9;
  localparam logic [1:0] SCALE_1X = 2'b01;
  localparam logic [2:0] PM_VERSION = 3'b010;

  localparam logic [1:0] ADDR_CAP  = 2'd0;
  localparam logic [1:0] ADDR_CSR  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef enum logic [PS_W-1:0] {PS_D0 = 2'b00, PS_D1 = 2'b01,
                                 PS_D2 = 2'b10, PS_D3 = 2'b11} pstate_e;

  function automatic logic state_ok(input logic [1:0] code, input logic [1:0] mask);
    case (code)
      PS_D1:   return mask[0];
      PS_D2:   return mask[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [CSR_W-1:0] cap_word(input logic [4:0] pme_states,
                                                input logic [1:0] mask);
    return {pme_states, mask[1], mask[0], 6'b0, PM_VERSION};
  endfunction

  function automatic logic [CSR_W-1:0] csr_word(input logic stat, input logic [SEL_W-1:0] sel,
                                                input logic en, input logic [PS_W-1:0] ps);
    return {stat, SCALE_1X, sel, en, 6'b0, ps};
  endfunction
endpackage

// File: rtl/pmc_state_reg.sv
module pmc_state_reg
  import pmc_pkg::*;
#(
  parameter logic [1:0] STATE_MASK = 2'b01
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_lo,
  input  logic [PS_W-1:0] wcode,
  output logic [PS_W-1:0] state,
  output logic            wr_reject
);
  logic accept;

  always_comb begin
    accept    = wr_lo && state_ok(wcode, STATE_MASK);
    wr_reject = wr_lo && !state_ok(wcode, STATE_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state <= PS_D0;
    else if (accept) state <= wcode;
  end
endmodule

// File: rtl/pmc_pme_ctl.sv
module pmc_pme_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wake,
  input  logic clr_hit,
  input  logic en_wr,
  input  logic en_val,
  output logic status,
  output logic enable,
  output logic req
);
  logic status_d, enable_d;

  always_comb begin
    status_d = wake ? 1'b1 : (clr_hit ? 1'b0 : status);
    enable_d = en_wr ? en_val : enable;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= 1'b0;
      enable <= 1'b0;
      req    <= 1'b0;
    end else begin
      status <= status_d;
      enable <= enable_d;
      req    <= status_d & enable_d;
    end
  end
endmodule

// File: rtl/pmc_data_sel.sv
module pmc_data_sel #(
  parameter int SEL_W   = 4,
  parameter int ENTRIES = 8,
  parameter int DATA_W  = 8,
  parameter logic [ENTRIES*DATA_W-1:0] TABLE = '0
) (
  input  logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] dout
);
  localparam int CODES = 1 << SEL_W;
  logic [DATA_W-1:0] entry [CODES];

  for (genvar g = 0; g < CODES; g++) begin : g_entry
    if (g < ENTRIES) begin : g_tab
      assign entry[g] = TABLE[g*DATA_W +: DATA_W];
    end else begin : g_zero
      assign entry[g] = '0;
    end
  end

  assign dout = entry[sel];
endmodule

// File: rtl/pm_csr_block.sv
module pm_csr_block
  import pmc_pkg::*;
#(
  parameter logic [1:0]  STATE_MASK = 2'b01,
  parameter logic [4:0]  PME_STATES = 5'b11001,
  parameter int          TBL_N      = 8,
  parameter int          BYTE_W     = 8,
  parameter logic [TBL_N*BYTE_W-1:0] DATA_TABLE = 64'h8776_6554_4332_2110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [1:0]        cfg_be,
  input  logic [CSR_W-1:0]  cfg_wdata,
  output logic [CSR_W-1:0]  cfg_rdata,
  input  logic              wake_evt,
  output logic              pme_req,
  output logic [PS_W-1:0]   pwr_state,
  output logic [BYTE_W-1:0] data_byte
);
  logic             csr_wr, wr_lo, wr_hi, clr_hit, wr_reject;
  logic             pme_status, pme_en;
  logic [SEL_W-1:0] sel_q;

  assign csr_wr  = cfg_wr && (cfg_addr == ADDR_CSR);
  assign wr_lo   = csr_wr && cfg_be[0];
  assign wr_hi   = csr_wr && cfg_be[1];
  assign clr_hit = wr_hi && cfg_wdata[BIT_STAT];

  pmc_state_reg #(.STATE_MASK(STATE_MASK)) u_state (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wcode(cfg_wdata[PS_W-1:0]),
    .state(pwr_state), .wr_reject(wr_reject)
  );

  pmc_pme_ctl u_pme (
    .clk(clk), .rst_n(rst_n), .wake(wake_evt), .clr_hit(clr_hit),
    .en_wr(wr_hi), .en_val(cfg_wdata[BIT_EN]),
    .status(pme_status), .enable(pme_en), .req(pme_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= '0;
    else if (wr_hi) sel_q <= cfg_wdata[SEL_LO +: SEL_W];
  end

  pmc_data_sel #(.SEL_W(SEL_W), .ENTRIES(TBL_N), .DATA_W(BYTE_W), .TABLE(DATA_TABLE)) u_data (
    .sel(sel_q), .dout(data_byte)
  );

  always_comb begin
    case (cfg_addr)
      ADDR_CAP:  cfg_rdata = cap_word(PME_STATES, STATE_MASK);
      ADDR_CSR:  cfg_rdata = csr_word(pme_status, sel_q, pme_en, pwr_state);
      ADDR_DATA: cfg_rdata = {{(CSR_W-BYTE_W){1'b0}}, data_byte};
      default:   cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [1:0]  cfg_addr,
  input logic [1:0]  cfg_be,
  input logic [15:0] cfg_wdata,
  input logic [15:0] cfg_rdata,
  input logic        wake_evt,
  input logic        pme_req,
  input logic [1:0]  pwr_state,
  input logic        pme_status,
  input logic        pme_en,
  input logic        clr_hit,
  input logic        wr_reject
);
  a_r3_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> $stable(pwr_state));

  a_r2_accept_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 2'd1 && cfg_be[0] && !wr_reject) |=> pwr_state == $past(cfg_wdata[1:0]));

  a_r4_wake_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> pme_status);

  a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !wake_evt) |=> (!pme_status && !pme_req));

  a_r6_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    pme_req |-> (pme_status && pme_en));

  a_r8_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == 2'd1) |-> (cfg_rdata[14:13] == 2'b01 && cfg_rdata[7:2] == 6'd0));
endmodule

bind pm_csr_block pmc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wake_evt(wake_evt), .pme_req(pme_req),
  .pwr_state(pwr_state), .pme_status(pme_status), .pme_en(pme_en),
  .clr_hit(clr_hit), .wr_reject(wr_reject)
);

// File: tb/test_pm_csr_block.sv
`timescale 1ns/1ps
module test_pm_csr_block;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = 2'd1;
  logic [1:0]  cfg_be = 2'b00;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        wake_evt = 1'b0;
  logic        pme_req;
  logic [1:0]  pwr_state;
  logic [7:0]  data_byte;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pm_csr_block i_pm_csr_block (.*);

  // {be[2], wdata[16], wake, exp_csr[16], exp_req, exp_state[2]}
  localparam logic [37:0] VEC [12] = '{
    {2'b01, 16'h0003, 1'b0, 16'h2003, 1'b0, 2'd3},  // R2 D3
    {2'b01, 16'h0002, 1'b0, 16'h2003, 1'b0, 2'd3},  // R3 D2 rejected
    {2'b01, 16'h0001, 1'b0, 16'h2001, 1'b0, 2'd1},  // R2 D1 accepted
    {2'b00, 16'h0000, 1'b1, 16'hA001, 1'b0, 2'd1},  // R4 wake, enable off
    {2'b10, 16'h0100, 1'b0, 16'hA101, 1'b1, 2'd1},  // R9 R5 enable, write 0 to status
    {2'b11, 16'h61FC, 1'b0, 16'hA100, 1'b1, 2'd0},  // R8 reserved and scale ignored
    {2'b10, 16'h8100, 1'b0, 16'h2100, 1'b0, 2'd0},  // R5 clear
    {2'b10, 16'h8100, 1'b1, 16'hA100, 1'b1, 2'd0},  // R7 set wins
    {2'b01, 16'h8000, 1'b0, 16'hA100, 1'b1, 2'd0},  // R12 high byte not enabled
    {2'b10, 16'h0E00, 1'b0, 16'hAE00, 1'b0, 2'd0},  // R6 enable off drops req
    {2'b10, 16'h9F00, 1'b0, 16'h3F00, 1'b0, 2'd0},  // R5 R9 clear, sel F, enable
    {2'b00, 16'h0000, 1'b1, 16'hBF00, 1'b1, 2'd0}   // R6 wake with enable
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] be, input logic [15:0] wd, input logic wk);
    @(negedge clk);
    cfg_addr = 2'd1; cfg_be = be; cfg_wdata = wd; wake_evt = wk;
    cfg_wr = (be != 2'b00);
    @(negedge clk);
    cfg_wr = 1'b0; wake_evt = 1'b0; cfg_be = 2'b00;
  endtask

  function automatic logic [7:0] tbl_byte(input int s);
    return (s < 8) ? 8'(8'h10 + 8'h11 * s) : 8'h00;
  endfunction

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 csr", cfg_rdata, 16'h2000);
    check("R1 req", {15'd0, pme_req}, 16'h0);
    check("R1 state", {14'd0, pwr_state}, 16'h0);
    check("R1 data", {8'd0, data_byte}, {8'd0, tbl_byte(0)});
    rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      step(VEC[i][37:36], VEC[i][35:20], VEC[i][19]);
      cfg_addr = 2'd1; #1;
      check($sformatf("R2-vec%0d csr", i), cfg_rdata, VEC[i][18:3]);
      check($sformatf("R6 vec%0d req", i), {15'd0, pme_req}, {15'd0, VEC[i][2]});
      check($sformatf("R3 vec%0d state", i), {14'd0, pwr_state}, {14'd0, VEC[i][1:0]});
    end

    // R10 data byte sweep over all select codes
    for (int s = 0; s < 16; s++) begin
      step(2'b10, 16'(s << 9), 1'b0);
      check($sformatf("R10 sel%0d port", s), {8'd0, data_byte}, {8'd0, tbl_byte(s)});
      cfg_addr = 2'd2; #1;
      check($sformatf("R10 sel%0d read", s), cfg_rdata, {8'd0, tbl_byte(s)});
    end

    // R11 capabilities word, default mask 01 and states 11001
    cfg_addr = 2'd0; #1;
    check("R11 cap", cfg_rdata, {5'b11001, 1'b0, 1'b1, 6'd0, 3'b010});

    // R3 D2 rejected from D3 too, D0 always accepted
    step(2'b01, 16'h0003, 1'b0);
    step(2'b01, 16'h0002, 1'b0);
    check("R3 D2 from D3", {14'd0, pwr_state}, 16'd3);
    step(2'b01, 16'h0000, 1'b0);
    check("R2 D0", {14'd0, pwr_state}, 16'd0);

    // R1 reset mid-run
    step(2'b11, 16'h0103, 1'b1);
    @(negedge clk); rst_n = 1'b0; cfg_addr = 2'd1; #1;
    check("R1 csr again", cfg_rdata, 16'h2000);
    check("R1 req again", {15'd0, pme_req}, 16'h0);
    check("R1 state again", {14'd0, pwr_state}, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule